// File: doc/BRIEF.md
# Line Transceiver Serial Control and Status Port

This block is the host-facing serial slave of a line transceiver. A host selects the block by pulling chip select low and clocks a 16-bit frame into it: a command byte, then a data byte, each least-significant bit first. A write programs the transmit equalizer code, the remote and local loopback modes and the all-ones transmit mode, and can also clear the latched alarm-change flags. A read returns the stored low bits of the data byte together with a 3-bit status code in the top three bit positions.

Two alarm levels come in from monitors outside the block: loss of received signal and loss of transmit driver activity. Any change of either level latches a flag and drives an active-low interrupt. A flag is released only when the host writes its clear bit while that level is low. Writing both loopback bits in one frame is treated as a reset request. The reset takes effect when chip select is released. It clears every register and gives a one-cycle reset pulse to the rest of the transceiver.

The serial pins are sampled on the system clock `clk` and are assumed to be synchronous to it. Each serial clock phase must last at least two `clk` cycles.

Top module: `xcvr_serial_ctl`

## Requirements
- R1: A frame starts only on a falling edge of `cs_n`. `sdi` is taken on each rising edge of `sclk`, least-significant bit first: 8 command bits, then 8 data bits. Any edges after the 16th bit are ignored until the next frame.
- R2: Command bit 0 selects read (1) or write (0). Command bits 5..1 carry address A4..A0, so A4 is command bit 5. The block acts only when A4 is 1, as in command 8'h20 (write) or 8'h21 (read). A frame with A4 = 0 changes no state and does not enable `sdo`.
- R3: A complete addressed write stores the data byte after its 16th bit. Bit 0 is the clear request for the loss-of-signal flag and bit 1 the clear request for the driver-alarm flag. `eq_code` takes bits 4..2, with bit 2 as its LSB. `rloop` takes bit 5, `lloop` bit 6, and the all-ones request bit 7.
- R4: An addressed read returns bits 4..0 of the last stored byte unchanged. Bits 5, 6 and 7 carry the status code.
- R5: The status code is written here as the values of bits 5, 6 and 7 in that order, and the first matching line applies. Both flags set gives 111. Only the loss-of-signal flag gives 110. Only the driver-alarm flag gives 101. Remote loopback gives 100. All-ones together with local loopback gives 011. Local loopback alone gives 010. All-ones alone gives 001. Otherwise the code is 000.
- R6: `sdo_oe` is high only while `cs_n` is low during the data byte of an addressed read. During a write frame and while `cs_n` is high it is low, and `sdo` then reads 0. Data bit k is for the host's sampling edge on serial pulse 8+k. With `clke` = 1 the host samples on the rising edge, and `sdo` changes on falling edges. With `clke` = 0 the host samples on the falling edge, and `sdo` changes on rising edges.
- R7: Any change of `los_in` or `dpm_in` sets the matching flag, and `int_n` goes low. A flag clears only when a write carries its clear bit while that input is low. `int_n` returns high when both flags are clear.
- R8: A write with bits 5 and 6 both set stores nothing. When `cs_n` then rises, `soft_rst` is high for exactly one cycle, and the stored byte and both flags become zero.
- R9: The `taos` output is the stored all-ones bit forced low while remote loopback is set. It can be high together with `lloop`.
- R10: A frame in which `cs_n` rises before the 16th bit leaves all state unchanged.
- R11: After `rst_n` the stored byte and both flags are zero, `int_n` is high and `sdo_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| clke | input | 1 | Selects the `sdo` update edge |
| los_in | input | 1 | Loss-of-signal level from the receive monitor |
| dpm_in | input | 1 | Driver-alarm level from the transmit monitor |
| sdo | output | 1 | Serial data out (0 when not driven) |
| sdo_oe | output | 1 | Output enable for `sdo` |
| int_n | output | 1 | Latched interrupt, active low |
| eq_code | output | 3 | Transmit equalizer code |
| rloop | output | 1 | Remote loopback enable |
| lloop | output | 1 | Local loopback enable |
| taos | output | 1 | All-ones transmit enable, inhibited by remote loopback |
| soft_rst | output | 1 | One-cycle transceiver reset pulse |

## Verification
The assertions check the following on every cycle:
- an input change always pulls `int_n` low on the next cycle, and it stays low until a clearing write;
- `sdo_oe` never rises before the command byte is complete;
- the status code is 111 whenever both flags are set;
- a reset pulse leaves the stored byte at zero;
- an aborted frame leaves the control state unchanged.

Only the bench scenarios can show the following:
- bit ordering and the data path through read-back;
- the full status priority against the modes;
- the two `clke` timings;
- the refusal of a clear while the alarm level is still high;
- the sequencing of the reset, which waits for chip select to rise.

// File: rtl/xcvr_serial_ctl.sv
module xcvr_serial_ctl #(
  parameter int CMD_W    = 8,
  parameter int DATA_W   = 8,
  parameter int ADDR_BIT = 5,
  parameter int EQ_W     = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic            sclk,
  input  logic            sdi,
  input  logic            clke,
  input  logic            los_in,
  input  logic            dpm_in,
  output logic            sdo,
  output logic            sdo_oe,
  output logic            int_n,
  output logic [EQ_W-1:0] eq_code,
  output logic            rloop,
  output logic            lloop,
  output logic            taos,
  output logic            soft_rst
);
  localparam int FRAME_W = CMD_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam int EQ_LO   = 2;
  localparam int RL_B    = 5;
  localparam int LL_B    = 6;
  localparam int AO_B    = 7;

  logic sclk_q, cs_q, los_q, dpm_q;
  logic [CNT_W-1:0]  cnt;
  logic              active;
  logic [CMD_W-1:0]  cmd_sr;
  logic [DATA_W-1:0] dat_sr, out_sr, ctrl;
  logic              rd_phase, sdo_r;
  logic              los_chg, dpm_chg, rst_pend, soft_rst_r;
  logic [2:0]        code;

  wire sclk_rise = sclk & ~sclk_q;
  wire sclk_fall = ~sclk & sclk_q;
  wire cs_fall   = ~cs_n & cs_q;
  wire cs_rise   = cs_n & ~cs_q;
  wire bit_in    = active & ~cs_n & sclk_rise & (cnt < CNT_W'(FRAME_W));
  wire last_cmd  = bit_in & (cnt == CNT_W'(CMD_W - 1));
  wire last_bit  = bit_in & (cnt == CNT_W'(FRAME_W - 1));

  wire [CMD_W-1:0]  cmd_now  = {sdi, cmd_sr[CMD_W-1:1]};
  wire [DATA_W-1:0] data_now = {sdi, dat_sr[DATA_W-1:1]};

  wire rd_start  = last_cmd & cmd_now[0] & cmd_now[ADDR_BIT];
  wire wr_commit = last_bit & ~cmd_sr[0] & cmd_sr[ADDR_BIT];
  wire rst_req   = wr_commit & data_now[RL_B] & data_now[LL_B];
  wire do_rst    = cs_rise & rst_pend;
  wire launch    = rd_phase & (clke ? sclk_fall : sclk_rise);

  wire los_ev  = los_in ^ los_q;
  wire dpm_ev  = dpm_in ^ dpm_q;
  wire los_clr = wr_commit & ~rst_req & data_now[0] & ~los_in;
  wire dpm_clr = wr_commit & ~rst_req & data_now[1] & ~dpm_in;
  wire taos_eff = ctrl[AO_B] & ~ctrl[RL_B];

  always_comb begin
    if (los_chg && dpm_chg)           code = 3'b111;
    else if (los_chg)                 code = 3'b110;
    else if (dpm_chg)                 code = 3'b101;
    else if (ctrl[RL_B])              code = 3'b100;
    else if (taos_eff && ctrl[LL_B])  code = 3'b011;
    else if (ctrl[LL_B])              code = 3'b010;
    else if (taos_eff)                code = 3'b001;
    else                              code = 3'b000;
  end

  wire [DATA_W-1:0] rd_byte = {code[0], code[1], code[2], ctrl[4:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b0;
      los_q  <= 1'b0;
      dpm_q  <= 1'b0;
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs_n;
      los_q  <= los_in;
      dpm_q  <= dpm_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      active <= 1'b0;
      cmd_sr <= '0;
      dat_sr <= '0;
    end else if (cs_fall) begin
      cnt    <= '0;
      active <= 1'b1;
    end else if (cs_rise) begin
      active <= 1'b0;
    end else if (bit_in) begin
      cnt <= cnt + 1'b1;
      if (cnt < CNT_W'(CMD_W)) cmd_sr <= cmd_now;
      else                     dat_sr <= data_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_phase <= 1'b0;
      out_sr   <= '0;
      sdo_r    <= 1'b0;
    end else if (cs_fall || cs_rise) begin
      rd_phase <= 1'b0;
      sdo_r    <= 1'b0;
    end else if (rd_start) begin
      rd_phase <= 1'b1;
      out_sr   <= rd_byte;
    end else if (launch) begin
      sdo_r  <= out_sr[0];
      out_sr <= {1'b0, out_sr[DATA_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl       <= '0;
      rst_pend   <= 1'b0;
      soft_rst_r <= 1'b0;
    end else begin
      soft_rst_r <= do_rst;
      if (do_rst) begin
        ctrl     <= '0;
        rst_pend <= 1'b0;
      end else if (cs_fall) begin
        rst_pend <= 1'b0;
      end else if (rst_req) begin
        rst_pend <= 1'b1;
      end else if (wr_commit) begin
        ctrl <= data_now;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      los_chg <= 1'b0;
      dpm_chg <= 1'b0;
    end else begin
      if (los_ev)                  los_chg <= 1'b1;
      else if (do_rst || los_clr)  los_chg <= 1'b0;
      if (dpm_ev)                  dpm_chg <= 1'b1;
      else if (do_rst || dpm_clr)  dpm_chg <= 1'b0;
    end
  end

  assign sdo_oe   = rd_phase & ~cs_n;
  assign sdo      = sdo_oe & sdo_r;
  assign int_n    = ~(los_chg | dpm_chg);
  assign eq_code  = ctrl[EQ_LO +: EQ_W];
  assign rloop    = ctrl[RL_B];
  assign lloop    = ctrl[LL_B];
  assign taos     = taos_eff;
  assign soft_rst = soft_rst_r;

  p_int_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (los_ev || dpm_ev) |=> !int_n);

  p_int_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_n && !wr_commit && !do_rst) |=> !int_n);

  p_oe_after_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> (cnt >= CNT_W'(CMD_W)));

  p_both_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (los_chg && dpm_chg) |-> (rd_byte[7:5] == 3'b111));

  p_reset_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> (ctrl == '0));

  p_abort_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !rst_pend) |=> $stable(ctrl));
endmodule

// File: tb/xcvr_serial_ctl_tb.sv
module xcvr_serial_ctl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;
  localparam logic [7:0] WR = 8'h20;
  localparam logic [7:0] RD = 8'h21;
  localparam int NV = 9;
  // {clke, write data, expected read}
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 8'h00, 8'h00},
    {1'b1, 8'h1C, 8'h1C},
    {1'b0, 8'h80, 8'h80},
    {1'b1, 8'h40, 8'h40},
    {1'b0, 8'hC0, 8'hC0},
    {1'b1, 8'h20, 8'h20},
    {1'b0, 8'hA0, 8'h20},
    {1'b1, 8'h0C, 8'h0C},
    {1'b0, 8'h13, 8'h13}
  };

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, clke = 1'b0;
  logic los_in = 1'b0, dpm_in = 1'b0;
  logic sdo, sdo_oe, int_n, rloop, lloop, taos, soft_rst;
  logic [2:0] eq_code;
  int nchk = 0, nfail = 0, oe_bad = 0, rst_pulses = 0;
  logic oe_allowed = 1'b0, done = 1'b0;
  logic [7:0] q, last;

  always #(CLK_PERIOD/2) clk = ~clk;

  xcvr_serial_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .clke(clke),
    .los_in(los_in), .dpm_in(dpm_in), .sdo(sdo), .sdo_oe(sdo_oe), .int_n(int_n),
    .eq_code(eq_code), .rloop(rloop), .lloop(lloop), .taos(taos), .soft_rst(soft_rst)
  );

  always @(negedge clk) begin
    if (sdo_oe && !oe_allowed) oe_bad++;
    if (soft_rst) rst_pulses++;
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic frame(input logic [7:0] c, input logic [7:0] d, input logic ck,
                       input int nbits, output logic [7:0] r);
    logic [15:0] w;
    w = {d, c};
    r = '0;
    clke = ck;
    oe_allowed = c[0];
    @(negedge clk); cs_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdi = w[i];
      sclk = 1'b0;
      repeat (HALF - 1) @(negedge clk);
      if (ck && i >= 8) r[i-8] = sdo;
      @(negedge clk); sclk = 1'b1;
      repeat (HALF - 1) @(negedge clk);
      if (!ck && i >= 8) r[i-8] = sdo;
      @(negedge clk);
    end
    sclk = 1'b0;
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
    oe_allowed = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    logic [7:0] r;
    frame(WR, d, 1'b0, 16, r);
  endtask

  task automatic rd(input logic ck, output logic [7:0] r);
    frame(RD, 8'h00, ck, 16, r);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R11 reset state
    chk("R11 int_n", 16'(int_n), 16'd1);
    chk("R11 sdo_oe", 16'(sdo_oe), 16'd0);
    chk("R11 ctrl outs", {11'd0, eq_code, rloop, lloop}, 16'd0);

    for (int v = 0; v < NV; v++) begin
      logic [7:0] d;
      d = VEC[v][15:8];
      wr(d);
      chk("R3 eq_code", 16'(eq_code), 16'(d[4:2]));
      chk("R3 loops", {14'd0, rloop, lloop}, {14'd0, d[5], d[6]});
      chk("R9 taos", 16'(taos), 16'(d[7] & ~d[5]));
      rd(VEC[v][16], q);
      chk("R4 R5 R6 R1 readback", 16'(q), 16'(VEC[v][7:0]));
    end
    last = 8'h13;

    // R2 wrong address
    frame(8'h10, 8'hFC, 1'b0, 16, q);
    rd(1'b1, q);
    chk("R2 write ignored", 16'(q), 16'(last));
    frame(8'h11, 8'h00, 1'b0, 16, q);
    chk("R2 read not driven", 16'(q), 16'd0);

    // R10 aborted frame
    frame(WR, 8'hDC, 1'b1, 12, q);
    rd(1'b0, q);
    chk("R10 abort discarded", 16'(q), 16'(last));
    chk("R10 eq unchanged", 16'(eq_code), 16'd4);

    // R7 / R5 alarm flags
    wr(8'h00);
    los_in = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 int on los", 16'(int_n), 16'd0);
    rd(1'b1, q);
    chk("R5 los code 110", 16'(q), 16'h60);
    wr(8'h01);
    chk("R7 clear refused while high", 16'(int_n), 16'd0);
    los_in = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 still latched", 16'(int_n), 16'd0);
    wr(8'h01);
    chk("R7 cleared", 16'(int_n), 16'd1);
    dpm_in = 1'b1;
    repeat (3) @(negedge clk);
    rd(1'b0, q);
    chk("R5 dpm code 101", 16'(q), 16'hA1);
    los_in = 1'b1;
    repeat (3) @(negedge clk);
    rd(1'b1, q);
    chk("R5 both code 111", 16'(q), 16'hE1);
    wr(8'h03);
    chk("R7 both refused", 16'(int_n), 16'd0);
    los_in = 1'b0; dpm_in = 1'b0;
    repeat (3) @(negedge clk);
    wr(8'h03);
    chk("R7 both cleared", 16'(int_n), 16'd1);
    wr(8'hC0);
    dpm_in = 1'b1;
    repeat (3) @(negedge clk);
    rd(1'b0, q);
    chk("R5 flag over modes", 16'(q), 16'hA0);
    dpm_in = 1'b0;
    repeat (3) @(negedge clk);
    wr(8'h02);
    chk("R7 dpm cleared", 16'(int_n), 16'd1);

    // R8 soft reset
    wr(8'h5C);
    los_in = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 pre-reset no pulse", 16'(rst_pulses), 16'd0);
    wr(8'h7C);
    chk("R8 one pulse", 16'(rst_pulses), 16'd1);
    chk("R8 outputs zero", {11'd0, eq_code, rloop, lloop}, 16'd0);
    chk("R8 flags zero", 16'(int_n), 16'd1);
    rd(1'b1, q);
    chk("R8 readback zero", 16'(q), 16'd0);

    chk("R6 oe off outside reads", 16'(oe_bad), 16'd0);
    finish_run();
  end
endmodule